// File: doc/BRIEF.md
# Multichannel periodic interrupt timer

This block holds eight independent periodic timers behind a small byte-wide register port. Two shared 8-bit prescalers ("micro time bases") count down from their own load values. Each gives a one-cycle tick when it wraps. Every channel owns a 16-bit down-counter that advances on the tick of the prescaler that its select bit names. When a channel's counter steps past zero, the counter reloads from that channel's load value and the channel's time-out flag sets in the same cycle.

A channel can instead be put in trigger mode. In that mode it ignores its select bit and counts every clock cycle in which its external trigger line, synchronized through two flops, is high. Each channel's interrupt output is the AND of its flag and its interrupt enable. Enabling the interrupt while a flag is already pending therefore asserts the request straight away. Flags are cleared by writing ones, and a new time-out in the same cycle as a clear takes priority over the clear.

Register map (byte offsets): 0x00 bit 0 = global run, 0x01 = channel enables, 0x02 = time-base select bits, 0x03 = trigger-mode enables, 0x04 = interrupt enables, 0x05 = time-out flags, 0x06 = prescaler 0 load, 0x07 = prescaler 1 load, 0x10 + 2·n = channel n load low byte, 0x11 + 2·n = channel n load high byte. Bit n of each per-channel register belongs to channel n. Unmapped offsets read as zero.

Top module: `tick_irq_timer`

## Requirements
- R1: After reset every register reads 0x00 and all interrupt outputs are low.
- R2: With global run set, a prescaler whose load is L ticks once every L+1 clock cycles; with global run clear neither prescaler ticks.
- R3: A running channel with load value C counts on its selected steps and sets its flag (bit n of offset 0x05) once every C+1 steps, reloading C in that cycle.
- R4: Select bit n = 0 routes prescaler 0 ticks to channel n and 1 routes prescaler 1 ticks; a change applies from the next cycle without waiting for any count boundary.
- R5: With trigger-mode bit n set, channel n steps on each cycle in which its trigger input, delayed through two flops, is high, and its select bit has no effect.
- R6: irq[n] is high exactly when flag n and interrupt-enable bit n are both set; writing the enable while the flag is set raises irq[n] after that write's clock edge.
- R7: Writing offset 0x05 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R8: When a clear write and a new time-out hit the same flag in one cycle, the flag stays set.
- R9: A channel whose enable bit is 0, or any channel while global run is 0, holds its counter at its load value and never sets its flag.
- R10: Every register listed in the map reads back the value last written (narrow fields zero-extended, flags as set by the timers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ext_trig | input | 8 | Per-channel trigger lines, asynchronous |
| irq | output | 8 | Per-channel interrupt requests |

## Verification
The two functions that meet in a single cycle are the write-one-to-clear of a flag and a fresh time-out on the same channel. A directed case makes a channel expire on every cycle (both loads zero) and then issues a clear write, sampling the flag just after that edge, where it must still read one. The random phase mixes clear writes, load changes, select flips and trigger noise against a cycle-level bench model, so coincident clears and time-outs, and select changes landing on tick cycles, are judged on both irq and read data every cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] A_GEN  = 5'h00;
  localparam logic [AW-1:0] A_CHEN = 5'h01;
  localparam logic [AW-1:0] A_SEL  = 5'h02;
  localparam logic [AW-1:0] A_TRG  = 5'h03;
  localparam logic [AW-1:0] A_INTE = 5'h04;
  localparam logic [AW-1:0] A_FLAG = 5'h05;
  localparam logic [AW-1:0] A_BLD0 = 5'h06;
  localparam logic [AW-1:0] A_BLD1 = 5'h07;
  localparam logic [AW-1:0] A_CHLD = 5'h10;

  localparam int unsigned NBASE = 2;
endpackage

// File: rtl/pit_base.sv
module pit_base #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] ld,
  output logic         tick
);
  logic [W-1:0] cnt;

  function automatic logic [W-1:0] base_next(logic r, logic t, logic [W-1:0] c, logic [W-1:0] l);
    if (!r || t) return l;
    return c - W'(1);
  endfunction

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= base_next(run, tick, cnt, ld);
  end
endmodule

// File: rtl/pit_chan.sv
module pit_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         step,
  input  logic [W-1:0] ld,
  output logic         expire
);
  logic [W-1:0] cnt;

  function automatic logic [W-1:0] chan_next(logic a, logic s, logic [W-1:0] c, logic [W-1:0] l);
    if (!a)          return l;
    if (!s)          return c;
    if (c == '0)     return l;
    return c - W'(1);
  endfunction

  assign expire = active && step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= chan_next(active, step, cnt, ld);
  end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned BW  = 8,
  parameter int unsigned CW  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 addr,
  input  logic                          wr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata,
  input  logic [NCH-1:0]                expire,
  output logic                          glb_en,
  output logic [NCH-1:0]                chen,
  output logic [NCH-1:0]                sel,
  output logic [NCH-1:0]                trge,
  output logic [NCH-1:0]                inte,
  output logic [NCH-1:0]                flags,
  output logic [NCH-1:0]                clr_mask,
  output logic [NBASE-1:0][BW-1:0]      base_ld,
  output logic [NCH-1:0][CW-1:0]        ch_ld
);
  localparam int unsigned NB = CW / 8;

  function automatic logic [AW-1:0] ld_byte_addr(int unsigned ch, int unsigned b);
    return AW'(int'(A_CHLD) + ch * NB + b);
  endfunction

  function automatic logic [NCH-1:0] flag_next(logic [NCH-1:0] f, logic [NCH-1:0] c, logic [NCH-1:0] e);
    return (f & ~c) | e;
  endfunction

  assign clr_mask = (wr && addr == A_FLAG) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      chen    <= '0;
      sel     <= '0;
      trge    <= '0;
      inte    <= '0;
      flags   <= '0;
      base_ld <= '0;
      ch_ld   <= '0;
    end else begin
      flags <= flag_next(flags, clr_mask, expire);
      if (wr) begin
        case (addr)
          A_GEN:   glb_en     <= wdata[0];
          A_CHEN:  chen       <= wdata[NCH-1:0];
          A_SEL:   sel        <= wdata[NCH-1:0];
          A_TRG:   trge       <= wdata[NCH-1:0];
          A_INTE:  inte       <= wdata[NCH-1:0];
          A_BLD0:  base_ld[0] <= wdata[BW-1:0];
          A_BLD1:  base_ld[1] <= wdata[BW-1:0];
          default: ;
        endcase
        for (int unsigned ch = 0; ch < NCH; ch++) begin
          for (int unsigned b = 0; b < NB; b++) begin
            if (addr == ld_byte_addr(ch, b)) ch_ld[ch][b*8 +: 8] <= wdata;
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_GEN:  rdata = 8'(glb_en);
      A_CHEN: rdata = 8'(chen);
      A_SEL:  rdata = 8'(sel);
      A_TRG:  rdata = 8'(trge);
      A_INTE: rdata = 8'(inte);
      A_FLAG: rdata = 8'(flags);
      A_BLD0: rdata = 8'(base_ld[0]);
      A_BLD1: rdata = 8'(base_ld[1]);
      default: begin
        for (int unsigned ch = 0; ch < NCH; ch++) begin
          for (int unsigned b = 0; b < NB; b++) begin
            if (addr == ld_byte_addr(ch, b)) rdata = ch_ld[ch][b*8 +: 8];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/tick_irq_timer.sv
module tick_irq_timer
  import pit_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned BW  = 8,
  parameter int unsigned CW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NCH-1:0]  ext_trig,
  output logic [NCH-1:0]  irq
);
  logic                     glb_en;
  logic [NCH-1:0]           chen, sel, trge, inte, flag_q, clr_mask;
  logic [NBASE-1:0][BW-1:0] base_ld;
  logic [NCH-1:0][CW-1:0]   ch_ld;

  // named internal events, observed by the bound checker
  logic [NBASE-1:0] base_tick;
  logic [NCH-1:0]   ch_step, ch_run, ch_expire;
  logic [NCH-1:0]   trig_meta, trig_sync;

  function automatic logic pick_step(logic ext, logic s, logic trg, logic [NBASE-1:0] tk);
    return ext ? trg : tk[s];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_meta <= '0;
      trig_sync <= '0;
    end else begin
      trig_meta <= ext_trig;
      trig_sync <= trig_meta;
    end
  end

  pit_regs #(.NCH(NCH), .BW(BW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .expire   (ch_expire),
    .glb_en   (glb_en),
    .chen     (chen),
    .sel      (sel),
    .trge     (trge),
    .inte     (inte),
    .flags    (flag_q),
    .clr_mask (clr_mask),
    .base_ld  (base_ld),
    .ch_ld    (ch_ld)
  );

  for (genvar b = 0; b < NBASE; b++) begin : g_base
    pit_base #(.W(BW)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (glb_en),
      .ld    (base_ld[b]),
      .tick  (base_tick[b])
    );
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign ch_run[ch]  = glb_en & chen[ch];
    assign ch_step[ch] = pick_step(trge[ch], sel[ch], trig_sync[ch], base_tick);
    pit_chan #(.W(CW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (ch_run[ch]),
      .step   (ch_step[ch]),
      .ld     (ch_ld[ch]),
      .expire (ch_expire[ch])
    );
  end

  assign irq = flag_q & inte;
endmodule

// File: rtl/pit_chk.sv
module pit_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           glb_en,
  input logic [NCH-1:0] chen,
  input logic [NCH-1:0] sel,
  input logic [NCH-1:0] trge,
  input logic [NCH-1:0] flag_q,
  input logic [NCH-1:0] clr_mask,
  input logic [NCH-1:0] irq,
  input logic [1:0]     base_tick,
  input logic [NCH-1:0] ch_step,
  input logic [NCH-1:0] ch_expire,
  input logic [NCH-1:0] trig_sync
);
  // R2
  base_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> base_tick == 2'b00);

  // R4
  sel0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_step & ~trge & ~sel & ~{NCH{base_tick[0]}}) == '0);

  // R4
  sel1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_step & ~trge & sel & ~{NCH{base_tick[1]}}) == '0);

  // R5
  trig_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_step ^ trig_sync) & trge) == '0);

  // R9
  idle_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_expire & ~(chen & {NCH{glb_en}})) == '0);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |ch_expire |=> ((flag_q & $past(ch_expire)) == $past(ch_expire)));

  // R7
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_mask |=> ((flag_q & $past(clr_mask & ~ch_expire)) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flag_q & ~$past(flag_q) & ~$past(ch_expire)) == '0));

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~flag_q) == '0);
endmodule

bind tick_irq_timer pit_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .chen      (chen),
  .sel       (sel),
  .trge      (trge),
  .flag_q    (flag_q),
  .clr_mask  (clr_mask),
  .irq       (irq),
  .base_tick (base_tick),
  .ch_step   (ch_step),
  .ch_expire (ch_expire),
  .trig_sync (trig_sync)
);

// File: tb/sim_tick_irq_timer.sv
`timescale 1ns/1ps
module sim_tick_irq_timer;
  import pit_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] ext_trig = '0;
  logic [7:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig), .irq(irq)
  );

  // ---------------- bench model ----------------
  logic        m_gen;
  logic [7:0]  m_chen, m_sel, m_trg, m_inte, m_flag, m_ld0, m_ld1, m_b0, m_b1, m_s1, m_s2;
  logic [15:0] m_chld [8];
  logic [15:0] m_cnt  [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gen = 0; m_chen = 0; m_sel = 0; m_trg = 0; m_inte = 0; m_flag = 0;
      m_ld0 = 0; m_ld1 = 0; m_b0 = 0; m_b1 = 0; m_s1 = 0; m_s2 = 0;
      for (int c = 0; c < 8; c++) begin m_chld[c] = 0; m_cnt[c] = 0; end
    end else begin
      bit t0, t1;
      logic [7:0] hit, clr;
      t0 = m_gen && (m_b0 == 0);
      t1 = m_gen && (m_b1 == 0);
      hit = 0;
      for (int c = 0; c < 8; c++) begin
        bit go, st;
        go = m_gen && m_chen[c];
        st = m_trg[c] ? m_s2[c] : (m_sel[c] ? t1 : t0);
        if (!go) m_cnt[c] = m_chld[c];
        else if (st) begin
          if (m_cnt[c] == 0) begin hit[c] = 1; m_cnt[c] = m_chld[c]; end
          else m_cnt[c] = m_cnt[c] - 1;
        end
      end
      m_b0 = (!m_gen || t0) ? m_ld0 : m_b0 - 1;
      m_b1 = (!m_gen || t1) ? m_ld1 : m_b1 - 1;
      clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata : 8'h00;
      m_flag = (m_flag & ~clr) | hit;
      m_s2 = m_s1;
      m_s1 = ext_trig;
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_gen  = bus_wdata[0];
          5'h01: m_chen = bus_wdata;
          5'h02: m_sel  = bus_wdata;
          5'h03: m_trg  = bus_wdata;
          5'h04: m_inte = bus_wdata;
          5'h06: m_ld0  = bus_wdata;
          5'h07: m_ld1  = bus_wdata;
          default: if (bus_addr[4]) begin
            if (bus_addr[0]) m_chld[int'(bus_addr[3:1])][15:8] = bus_wdata;
            else             m_chld[int'(bus_addr[3:1])][7:0]  = bus_wdata;
          end
        endcase
      end
    end
  end

  function automatic logic [7:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return {7'b0, m_gen};
      5'h01: return m_chen;
      5'h02: return m_sel;
      5'h03: return m_trg;
      5'h04: return m_inte;
      5'h05: return m_flag;
      5'h06: return m_ld0;
      5'h07: return m_ld1;
      default: begin
        if (!a[4]) return 8'h00;
        return a[0] ? m_chld[int'(a[3:1])][15:8] : m_chld[int'(a[3:1])][7:0];
      end
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R6: interrupt level matches model flags AND enables, every cycle
  always @(negedge clk) begin
    if (rst_n) chk("R6", "irq vs flag&enable", irq, m_flag & m_inte);
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  // cycles between two consecutive sets of flag ch (clears between them)
  task automatic flag_interval(input int ch, output int d);
    int a0;
    a0 = -1; d = -1;
    wr(A_FLAG, 8'(1 << ch));
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      bus_addr = A_FLAG;
      #1;
      if (bus_rdata[ch]) begin
        if (a0 < 0) begin a0 = cyc; wr(A_FLAG, 8'(1 << ch)); end
        else begin d = cyc - a0; break; end
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int d;
    int seen;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 32; a++) begin
      bus_addr = 5'(a);
      #1 chk("R1", $sformatf("reset read %0h", a), bus_rdata, 8'h00);
    end
    chk("R1", "reset irq", irq, 8'h00);

    // R10 register readback (global run still off)
    wr(A_CHEN, 8'hA5); wr(A_SEL, 8'h3C); wr(A_TRG, 8'h81);
    wr(A_INTE, 8'h7E); wr(A_BLD0, 8'h11); wr(A_BLD1, 8'hEE);
    for (int c = 0; c < 8; c++) begin
      wr(5'(16 + 2 * c), 8'(c * 17 + 3));
      wr(5'(17 + 2 * c), 8'(8'h80 | c));
    end
    rd(A_CHEN, v); chk("R10", "chen readback", v, 8'hA5);
    rd(A_SEL,  v); chk("R10", "select readback", v, 8'h3C);
    rd(A_TRG,  v); chk("R10", "trigger-mode readback", v, 8'h81);
    rd(A_INTE, v); chk("R10", "inte readback", v, 8'h7E);
    rd(A_BLD0, v); chk("R10", "base0 load readback", v, 8'h11);
    rd(A_BLD1, v); chk("R10", "base1 load readback", v, 8'hEE);
    for (int c = 0; c < 8; c++) begin
      rd(5'(16 + 2 * c), v); chk("R10", "chan load low", v, 8'(c * 17 + 3));
      rd(5'(17 + 2 * c), v); chk("R10", "chan load high", v, 8'(8'h80 | c));
    end
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, v); chk("R7", "clear of empty flags", v, 8'h00);
    wr(A_GEN, 8'h01);
    rd(A_GEN, v); chk("R10", "global run readback", v, 8'h01);
    wr(A_GEN, 8'h00);
    wr(A_CHEN, 0); wr(A_SEL, 0); wr(A_TRG, 0); wr(A_INTE, 0);
    for (int c = 0; c < 8; c++) begin wr(5'(16 + 2 * c), 0); wr(5'(17 + 2 * c), 0); end

    // R2 base0 period
    wr(A_BLD0, 8'd3); wr(A_CHEN, 8'h01); wr(A_GEN, 8'h01);
    flag_interval(0, d); chk("R2", "base0 load 3 interval", d, 4);
    // R4 select base1
    wr(A_BLD1, 8'd6); wr(A_SEL, 8'h01);
    flag_interval(0, d); chk("R4", "select 1 uses base1 load 6", d, 7);
    // R3 channel load
    wr(A_SEL, 8'h00); wr(A_BLD0, 8'd0); wr(5'h10, 8'd2);
    flag_interval(0, d); chk("R3", "chan load 2 interval", d, 3);

    // R4 immediate switch: base1 slow, base0 every cycle
    wr(A_BLD1, 8'd200); wr(5'h10, 8'd9); wr(A_SEL, 8'h01);
    repeat (5) @(negedge clk);
    wr(A_FLAG, 8'h01);
    wr(A_SEL, 8'h00);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); bus_addr = A_FLAG;
      #1 if (bus_rdata[0]) seen = 1;
    end
    chk("R4", "switch to base0 takes effect at once", seen, 1);

    // R5 trigger mode: select ignored, counts trigger-high cycles
    wr(5'h10, 8'd4); ext_trig = 8'h01; wr(A_TRG, 8'h01);
    flag_interval(0, d); chk("R5", "trigger held high, load 4", d, 5);
    ext_trig = 8'h00;
    repeat (4) @(negedge clk);
    wr(A_FLAG, 8'h01);
    repeat (40) @(negedge clk);
    rd(A_FLAG, v); chk("R5", "trigger low stops counting", v[0], 1'b0);

    // R9 disabled channel / global off
    wr(A_TRG, 0); wr(A_SEL, 0); wr(5'h10, 0); wr(A_CHEN, 0);
    repeat (5) @(negedge clk);
    wr(A_FLAG, 8'hFF);
    repeat (20) @(negedge clk);
    rd(A_FLAG, v); chk("R9", "disabled channel sets no flag", v, 8'h00);
    wr(A_CHEN, 8'h01); wr(A_GEN, 8'h00);
    repeat (5) @(negedge clk);
    wr(A_FLAG, 8'hFF);
    repeat (20) @(negedge clk);
    rd(A_FLAG, v); chk("R9", "global off sets no flag", v, 8'h00);
    wr(A_GEN, 8'h01);

    // R8 clear and time-out in the same cycle (expires every cycle)
    repeat (3) @(negedge clk);
    wr(A_FLAG, 8'h01);
    bus_addr = A_FLAG;
    #1 chk("R8", "set wins over clear", bus_rdata[0], 1'b1);

    // R7 write-one-to-clear
    wr(A_CHEN, 8'h00);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, v); chk("R7", "write 0 keeps flag", v[0], 1'b1);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, v); chk("R7", "write 1 clears flag", v[0], 1'b0);

    // R6 enabling while pending
    wr(A_CHEN, 8'h01); wr(A_CHEN, 8'h00);
    chk("R6", "pending flag, enable off", irq[0], 1'b0);
    wr(A_INTE, 8'h01);
    #1 chk("R6", "enable while pending fires", irq[0], 1'b1);
    wr(A_FLAG, 8'h01);
    #1 chk("R6", "clear drops irq", irq[0], 1'b0);
    wr(A_INTE, 8'h00);

    // random phase, checked against the model (R3 R4 R5 R7 R8 R10)
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ext_trig = 8'($urandom);
      if ($urandom % 3 == 0) begin
        int k;
        logic [4:0] a;
        logic [7:0] dd;
        k = int'($urandom % 24);
        a = (k < 8) ? 5'(k) : 5'(16 + k - 8);
        dd = 8'($urandom);
        if (a == A_GEN) dd = ($urandom % 6 != 0) ? 8'h01 : 8'h00;
        else if (a == A_BLD0 || a == A_BLD1) dd = 8'($urandom % 5);
        else if (a[4] && !a[0]) dd = 8'($urandom % 10);
        else if (a[4] && a[0]) dd = ($urandom % 16 == 0) ? 8'h01 : 8'h00;
        bus_addr = a; bus_wdata = dd; bus_wr = 1'b1;
      end else begin
        bus_wr = 1'b0;
        bus_addr = 5'($urandom);
        #1 chk("R10", $sformatf("random read %0h", bus_addr), bus_rdata, m_read(bus_addr));
      end
    end
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule